// File: doc/BRIEF.md
# Key-Sequenced Windowed Watchdog

This block is a watchdog timer reached over a small memory-mapped register bus. A free-running counter advances once per clock while the watchdog is enabled. When it reaches the programmed timeout, the block asks the system for a reset. Software keeps the system alive by writing a two-word service key to the key register, which returns the counter to zero. With a non-zero window value, a service that comes too early is treated as a fault, and so is a wrong second key word.

Reconfiguration can be protected. While the update-permit bit is clear, software writes the configuration registers directly. Once that bit is set, configuration writes are dropped unless a two-word unlock key has just opened a time-limited configuration window. Software normally ends its setup by writing 0x120 to the control register. This leaves the counter stopped and the protection armed, so a later stage can unlock and reconfigure the block.

Top module: `wdt_windowed`

## Requirements
- R1: Register offsets are control 0x0, key/counter 0x4, timeout 0x8 and window 0xC. In the control register, bit 7 is enable, bit 5 is update-permit and bit 14 is the sticky timeout flag. Read data appears on the clock after a read strobe. After reset, control reads 0x80 (enabled, unprotected), timeout reads 0x400, window reads 0 and the reset request is low.
- R2: While enabled, the counter (read at 0x4) increases by one each clock. While disabled it holds its value.
- R3: When the enabled counter equals the timeout, the reset request goes high for exactly one clock and the counter restarts at zero, giving a period of timeout+1 clocks. The timeout flag is set at the same time. Writing 1 to bit 14 clears the flag, and writing 0 leaves it set.
- R4: Writing 0xA602 and then 0xB480 to 0x4, with the second word at most 16 clocks after the first, reloads the counter to zero. A second word that arrives 17 or more clocks late, or any other value written in between, cancels the pair.
- R5: With update-permit clear, the control, timeout and window registers take writes directly, and the unlock key opens no configuration window.
- R6: With update-permit set, writes to control, timeout and window are ignored. The exception is the 128 clocks that follow an unlock pair (0xC520 then 0xD928 at 0x4, second word within 16 clocks). A write on the 128th clock after the pair is accepted and a write on the 129th is ignored.
- R7: Writing 0x120 to control stops the counter and leaves update-permit set (control reads 0x20).
- R8: With a non-zero window value, a service pair that completes while the counter is below the window value raises the reset request for one clock and does not reload the counter. A service pair at or above the window value reloads normally. A window value of 0 accepts a service pair at any time.
- R9: With a non-zero window value and the watchdog enabled, a wrong word following 0xA602 raises the reset request for one clock. With a window value of 0 it does not.
- R10: A service pair whose second word lands on the clock where the counter equals the timeout does not prevent expiry: the reset request pulses, the flag is set and the counter restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rst_req | output | 1 | One-clock reset request |

## Verification
Two functions can meet on one clock: completion of a service key pair, and the counter matching the timeout. The bench stops the counter, reloads it to zero, enables it at a known clock edge and places the second key word exactly on the edge where the count equals the timeout. It then checks for the reset pulse, the sticky flag and a counter that has restarted. A run that is one clock earlier must instead be accepted as a plain service with no pulse, which shows the priority is decided on that single edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Register byte offsets (the key register offset is shared with the counter readback)
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_KEY  = 4'h4;
  localparam logic [3:0] OFS_TOV  = 4'h8;
  localparam logic [3:0] OFS_WIN  = 4'hC;

  // Control register bit positions
  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_UPD_BIT  = 5;
  localparam int CTRL_FLAG_BIT = 14;

  // Key sequence table: index 0 unlocks, index 1 services
  localparam int SEQ_UNLOCK  = 0;
  localparam int SEQ_REFRESH = 1;
  localparam int SEQ_NUM     = 2;
  localparam logic [15:0] KEY_HEAD [SEQ_NUM] = '{16'hC520, 16'hA602};
  localparam logic [15:0] KEY_TAIL [SEQ_NUM] = '{16'hD928, 16'hB480};

  typedef enum logic {KS_IDLE = 1'b0, KS_ARMED = 1'b1} key_state_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter int GAP    = 16,
  parameter logic [KEY_W-1:0] HEAD = '0,
  parameter logic [KEY_W-1:0] TAIL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  output logic              seq_done,
  output logic              seq_fail
);
  localparam int GW = $clog2(GAP + 1);

  key_state_e    st;
  logic [GW-1:0] gap;
  logic          is_head;
  logic          is_tail;

  assign is_head = (key_data == DATA_W'(HEAD));
  assign is_tail = (key_data == DATA_W'(TAIL));

  // Outcome is decided in the cycle the following key word is presented
  assign seq_done = (st == KS_ARMED) && key_we && is_tail;
  assign seq_fail = (st == KS_ARMED) && key_we && !is_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= KS_IDLE;
      gap <= '0;
    end else if (key_we) begin
      st  <= is_head ? KS_ARMED : KS_IDLE;
      gap <= GW'(1);
    end else if (st == KS_ARMED) begin
      if (gap == GW'(GAP)) st <= KS_IDLE;
      else                 gap <= gap + GW'(1);
    end
  end
endmodule

// File: rtl/wdt_cfg_gate.sv
module wdt_cfg_gate #(
  parameter int OPEN = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic unlock_done,
  input  logic permit,
  output logic open
);
  localparam int OW = $clog2(OPEN + 1);

  logic [OW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                          left <= '0;
    else if (unlock_done && permit)   left <= OW'(OPEN);
    else if (left != '0)              left <= left - OW'(1);
  end

  assign open = (left != '0);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  input  logic [CNT_W-1:0] win,
  input  logic             ref_done,
  input  logic             ref_fail,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             rst_req,
  output logic             flag
);
  logic win_on;
  logic expire;
  logic early;
  logic bad_key;

  assign win_on  = (win != '0);
  assign expire  = run && (cnt == limit);
  assign early   = ref_done && run && win_on && (cnt < win);
  assign bad_key = ref_fail && run && win_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      rst_req <= 1'b0;
      flag    <= 1'b0;
    end else begin
      rst_req <= expire || early || bad_key;
      // expiry sets the flag even if software clears it on the same clock
      if (expire)        flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (expire || (ref_done && !early)) cnt <= '0;
      else if (run)                       cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int KEY_GAP  = 16,
  parameter int CFG_OPEN = 128,
  parameter int TOV_RST  = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_TOV  = ADDR_W'(OFS_TOV);
  localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(OFS_WIN);

  logic               en_q;
  logic               upd_q;
  logic [CNT_W-1:0]   tov_q;
  logic [CNT_W-1:0]   win_q;
  logic [CNT_W-1:0]   cnt_val;
  logic               flag_q;
  logic               cfg_open;
  logic               cfg_ok;
  logic               key_we;
  logic               flag_clr;
  logic [SEQ_NUM-1:0] seq_done;
  logic [SEQ_NUM-1:0] seq_fail;
  logic               unlock_done;
  logic               refresh_done;
  logic               refresh_fail;
  logic               unused_unlock_fail;
  logic [DATA_W-1:0]  ctrl_view;

  assign key_we = bus_we && (bus_addr == A_KEY);

  for (genvar g = 0; g < SEQ_NUM; g++) begin : g_seq
    wdt_key_seq #(
      .DATA_W (DATA_W),
      .KEY_W  (16),
      .GAP    (KEY_GAP),
      .HEAD   (KEY_HEAD[g]),
      .TAIL   (KEY_TAIL[g])
    ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .key_we   (key_we),
      .key_data (bus_wdata),
      .seq_done (seq_done[g]),
      .seq_fail (seq_fail[g])
    );
  end

  assign unlock_done        = seq_done[SEQ_UNLOCK];
  assign refresh_done       = seq_done[SEQ_REFRESH];
  assign refresh_fail       = seq_fail[SEQ_REFRESH];
  assign unused_unlock_fail = seq_fail[SEQ_UNLOCK];

  wdt_cfg_gate #(.OPEN(CFG_OPEN)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .unlock_done (unlock_done),
    .permit      (upd_q),
    .open        (cfg_open)
  );

  assign cfg_ok   = !upd_q || cfg_open;
  assign flag_clr = bus_we && (bus_addr == A_CTRL) && bus_wdata[CTRL_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b1;
      upd_q <= 1'b0;
      tov_q <= CNT_W'(TOV_RST);
      win_q <= '0;
    end else if (bus_we && cfg_ok) begin
      case (bus_addr)
        A_CTRL: begin
          en_q  <= bus_wdata[CTRL_EN_BIT];
          upd_q <= bus_wdata[CTRL_UPD_BIT];
        end
        A_TOV:   tov_q <= bus_wdata[CNT_W-1:0];
        A_WIN:   win_q <= bus_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (en_q),
    .limit    (tov_q),
    .win      (win_q),
    .ref_done (refresh_done),
    .ref_fail (refresh_fail),
    .flag_clr (flag_clr),
    .cnt      (cnt_val),
    .rst_req  (rst_req),
    .flag     (flag_q)
  );

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_EN_BIT]   = en_q;
    ctrl_view[CTRL_UPD_BIT]  = upd_q;
    ctrl_view[CTRL_FLAG_BIT] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_KEY:   bus_rdata <= DATA_W'(cnt_val);
        A_TOV:   bus_rdata <= DATA_W'(tov_q);
        A_WIN:   bus_rdata <= DATA_W'(win_q);
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_windowed_chk.sv
module wdt_windowed_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              flag_wbit,
  input logic              en_q,
  input logic              upd_q,
  input logic              cfg_open,
  input logic [CNT_W-1:0]  tov_q,
  input logic [CNT_W-1:0]  win_q,
  input logic [CNT_W-1:0]  cnt_val,
  input logic              rst_req,
  input logic              flag_q,
  input logic              unlock_done,
  input logic              refresh_done
);
  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !refresh_done) |=> $stable(cnt_val)) else $error("R2 counter moved while stopped");

  assert_timeout_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (en_q && cnt_val == tov_q) |=> (rst_req && flag_q && cnt_val == '0)) else $error("R3 expiry not signalled");

  assert_flag_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(bus_we && bus_addr == ADDR_W'(wdt_pkg::OFS_CTRL) && flag_wbit))
    else $error("R3 flag dropped without clear write");

  assert_refresh_reload_R4: assert property (@(posedge clk) disable iff (rst)
    (refresh_done && !en_q) |=> (cnt_val == '0)) else $error("R4 service did not reload");

  assert_unlock_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    (unlock_done && !upd_q && !cfg_open) |=> !cfg_open) else $error("R5 unlock opened window");

  assert_locked_timeout_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_q && !cfg_open) |=> ($stable(tov_q) && $stable(win_q))) else $error("R6 locked config changed");

  assert_early_service_R8: assert property (@(posedge clk) disable iff (rst)
    (refresh_done && en_q && win_q != '0 && cnt_val < win_q) |=> rst_req) else $error("R8 early service missed");
endmodule

bind wdt_windowed wdt_windowed_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .flag_wbit    (bus_wdata[wdt_pkg::CTRL_FLAG_BIT]),
  .en_q         (en_q),
  .upd_q        (upd_q),
  .cfg_open     (cfg_open),
  .tov_q        (tov_q),
  .win_q        (win_q),
  .cnt_val      (cnt_val),
  .rst_req      (rst_req),
  .flag_q       (flag_q),
  .unlock_done  (unlock_done),
  .refresh_done (refresh_done)
);

// File: tb/wdt_windowed_tb.sv
module wdt_windowed_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rreq;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_windowed u_dut (
    .clk (clk), .rst (rst), .bus_we (we), .bus_re (re), .bus_addr (addr),
    .bus_wdata (wdata), .bus_rdata (rdata), .rst_req (rreq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; we = 1'b0; re = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // write sampled on the edge that follows the drive; s = that edge number
  task automatic wr_s(input logic [3:0] a, input logic [31:0] d, output int s);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; s = cyc + 1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    int s;
    wr_s(a, d, s);
  endtask

  // write sampled exactly on edge tgt (caller sits at a negedge before it)
  task automatic wr_at(input logic [3:0] a, input logic [31:0] d, input int tgt);
    while (cyc != tgt - 1) @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; v = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 rst_req low", {31'b0, rreq}, 32'h0);
    rd(4'h0, v); chk("R1 ctrl reset", v, 32'h80);
    rd(4'h8, v); chk("R1 timeout reset", v, 32'h400);
    rd(4'hC, v); chk("R1 window reset", v, 32'h0);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    do_reset();
    rd(4'h4, a); rd(4'h4, b);
    chk("R2 counting step", b - a, 32'd2);
    wr(4'h0, 32'h0);
    rd(4'h4, a); rd(4'h4, b);
    chk("R2 held while stopped", b, a);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    int p1, p2;
    do_reset();
    wr(4'h8, 32'd20);
    p1 = -1; p2 = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rreq) begin p1 = cyc; break; end
    end
    @(negedge clk);
    chk("R3 pulse one clock", {31'b0, rreq}, 32'h0);
    for (int i = 0; i < 200; i++) begin
      if (rreq) begin p2 = cyc; break; end
      @(negedge clk);
    end
    chk("R3 expiry period", p2 - p1, 32'd21);
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R3 flag survives zero write", v, 32'h4000);
    wr(4'h0, 32'h4000);
    rd(4'h0, v); chk("R3 flag cleared by one", v, 32'h0);
  endtask

  task automatic t_refresh();
    logic [31:0] v;
    int s;
    do_reset();
    repeat (40) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    rd(4'h4, v); chk("R4 service reloads", v, 32'd1);
    repeat (40) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'h1234); wr(4'h4, 32'hB480);
    rd(4'h4, v); chk("R4 interrupted pair ignored", {31'b0, v > 32'd10}, 32'h1);
    wr_s(4'h4, 32'hA602, s); wr_at(4'h4, 32'hB480, s + 16);
    rd(4'h4, v); chk("R4 gap of 16 accepted", v, 32'd1);
    repeat (40) @(negedge clk);
    wr_s(4'h4, 32'hA602, s); wr_at(4'h4, 32'hB480, s + 17);
    rd(4'h4, v); chk("R4 gap of 17 rejected", {31'b0, v > 32'd10}, 32'h1);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    int u;
    do_reset();
    wr(4'h8, 32'h30);
    rd(4'h8, v); chk("R5 direct timeout write", v, 32'h30);
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    wr(4'h0, 32'h20);
    wr(4'h8, 32'h44);
    rd(4'h8, v); chk("R5 unlock without permit opens nothing", v, 32'h30);
    do_reset();
    wr(4'h8, 32'h30);
    wr(4'h0, 32'h120);
    rd(4'h0, v); chk("R7 ctrl after 0x120", v, 32'h20);
    rd(4'h4, u); rd(4'h4, v); chk("R7 counter stopped", v, u);
    wr(4'h8, 32'h55);
    rd(4'h8, v); chk("R6 locked write ignored", v, 32'h30);
    wr(4'h4, 32'hC520); wr_s(4'h4, 32'hD928, u);
    wr_at(4'h8, 32'h77, u + 128);
    rd(4'h8, v); chk("R6 write on last open clock", v, 32'h77);
    wr(4'h4, 32'hC520); wr_s(4'h4, 32'hD928, u);
    wr_at(4'h8, 32'h88, u + 129);
    rd(4'h8, v); chk("R6 write after window", v, 32'h77);
    wr_s(4'h4, 32'hC520, u); wr_at(4'h4, 32'hD928, u + 17);
    wr(4'h8, 32'h99);
    rd(4'h8, v); chk("R6 late unlock rejected", v, 32'h77);
    wr(4'h0, 32'h80);
    rd(4'h0, v); chk("R6 locked ctrl ignored", v, 32'h20);
  endtask

  task automatic t_window();
    logic [31:0] v;
    do_reset();
    wr(4'hC, 32'd30);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    chk("R8 early service pulses", {31'b0, rreq}, 32'h1);
    rd(4'h4, v); chk("R8 early service no reload", {31'b0, v > 32'd2}, 32'h1);
    repeat (40) @(negedge clk);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    chk("R8 in-window service quiet", {31'b0, rreq}, 32'h0);
    rd(4'h4, v); chk("R8 in-window service reloads", v, 32'd1);
    wr(4'h4, 32'hA602); wr(4'h4, 32'h1111);
    chk("R9 wrong key pulses", {31'b0, rreq}, 32'h1);
    wr(4'hC, 32'd0);
    wr(4'h4, 32'hA602); wr(4'h4, 32'h1111);
    chk("R9 wrong key quiet without window", {31'b0, rreq}, 32'h0);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    chk("R8 window off no pulse", {31'b0, rreq}, 32'h0);
    rd(4'h4, v); chk("R8 window off reloads", v, 32'd1);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int e;
    do_reset();
    wr(4'h0, 32'h0);
    wr(4'h8, 32'd40);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    wr_s(4'h0, 32'h80, e);
    wr_at(4'h4, 32'hA602, e + 39); wr_at(4'h4, 32'hB480, e + 40);
    chk("R10 service one clock early quiet", {31'b0, rreq}, 32'h0);
    rd(4'h0, v); chk("R10 no flag when early", v, 32'h80);
    wr(4'h0, 32'h0);
    wr(4'h4, 32'hA602); wr(4'h4, 32'hB480);
    wr_s(4'h0, 32'h80, e);
    wr_at(4'h4, 32'hA602, e + 40); wr_at(4'h4, 32'hB480, e + 41);
    chk("R10 collision pulses", {31'b0, rreq}, 32'h1);
    rd(4'h4, v); chk("R10 counter restarted", v, 32'd1);
    rd(4'h0, v); chk("R10 flag set", v, 32'h4080);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_timeout();
    t_refresh();
    t_lock();
    t_window();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule